// File: doc/BRIEF.md
# Vectored Interrupt Controller with Latched Active Vector

This block gathers up to 128 level-sensitive interrupt inputs. It combines each input with a software trigger bit and filters the result through a per-line mask. It then reduces the surviving requests to a single line number. That number is latched and held, and a single request line to the processor stays high, until software acknowledges the interrupt with an end-of-interrupt write to the control register.

The lines are organised in banks of 32. Line k belongs to bank k>>5, at bit k&31. Each bank has four write-one addresses: two update the mask bits and two update the software trigger bits. All access goes through a plain 32-bit register port with a one-cycle registered read path.

Software can restart the block's state at any time with a soft reset command. A status bit shows when that reset has completed. When software reads the active-number register, it learns whether the latched line is still a genuine request. If the line is no longer a genuine request, a spurious flag is set in the value read back.

Top module: `irqv_ctrl`

## Requirements
- R1: After hardware reset every mask bit is 1, every software trigger bit is 0, the threshold register holds 0xFF, status bit 0 reads 1 and `cpu_irq` is low.
- R2: Register offsets are: revision 0x00, config 0x10, status 0x14, active number 0x40, control 0x48, threshold 0x68. A read started with `bus_rd_en` appears on `bus_rdata` after the next clock edge and is held until the next read. Reading any address not listed in R2 or R3 returns 0.
- R3: Bank n (0..3) uses four addresses: mask clear at 0x88+0x20*n, mask set at 0x8C+0x20*n, trigger set at 0x90+0x20*n and trigger clear at 0x94+0x20*n. Line k maps to bank k>>5, bit k&31. Reading either mask address returns the bank's mask bits, and reading either trigger address returns the bank's trigger bits.
- R4: In the four bank registers, each written 1 bit sets or clears the matching state bit, and each written 0 bit leaves that state bit unchanged.
- R5: A line requests service when (input OR trigger bit) is 1 and its mask bit is 0. A masked line never raises `cpu_irq`.
- R6: When several lines request service at the moment a vector is picked, the lowest line number is chosen.
- R7: When no vector is latched and some line requests service, the lowest such line is latched at the next clock edge. `cpu_irq` is high exactly while a vector is latched.
- R8: A latched vector is held until a write with bit 0 set reaches the control register. At that edge, the lowest line requesting service at that same edge is latched. If no line is requesting service, the block goes idle and `cpu_irq` falls.
- R9: Reading the active-number register returns the latched line number in bits 6:0. Bit 7 is set when no vector is latched, or when the latched line no longer requests service. Bits 31:8 read 0. Writes to this register have no effect.
- R10: A write with bit 1 set to the config register starts a soft reset. Status bit 0 then reads 0 for 4 cycles. Masks, trigger bits, threshold and the latched vector return to their R1 values, and bus writes are ignored until the soft reset completes.
- R11: The threshold register is an 8-bit read/write register with no effect on selection. The revision register reads major version 2 in bits 7:4 and minor version 1 in bits 3:0 (0x21).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_BANKS*32 | Level interrupt inputs, line k on bit k |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
Two events can fall on the same clock edge: the end-of-interrupt write and a new input line rising. The bench provokes this by raising a lower-numbered input in the very cycle that carries the acknowledge write. It then reads the active-number register and expects the newly risen line, not the older, higher one that was still pending. A second overlap is a read of the active-number register after the latched line has lost its request. That read must return the old number with the spurious bit set, while `cpu_irq` stays high.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
   localparam int WORD_W      = 32;
   localparam int OFS_REV     = 'h00;
   localparam int OFS_SYSCFG  = 'h10;
   localparam int OFS_SYSSTAT = 'h14;
   localparam int OFS_ACTIVE  = 'h40;
   localparam int OFS_CTRL    = 'h48;
   localparam int OFS_THRESH  = 'h68;
   localparam int OFS_BANK0   = 'h88;
   localparam int BANK_STRIDE = 'h20;
   localparam int SPUR_BIT    = 7;
   localparam int CFG_SRST_BIT = 1;
   localparam int CTRL_EOI_BIT = 0;

   typedef enum int {
      BK_MASK_CLR = 0,
      BK_MASK_SET = 4,
      BK_TRIG_SET = 8,
      BK_TRIG_CLR = 12
   } bank_reg_e;

   function automatic int bank_addr(input int bank, input bank_reg_e which);
      return OFS_BANK0 + bank * BANK_STRIDE + int'(which);
   endfunction
endpackage

// File: rtl/irqv_bank.sv
module irqv_bank
   import irqv_pkg::*;
#(
   parameter int LINES = WORD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic             mask_clr,
   input  logic             mask_set,
   input  logic             trig_set,
   input  logic             trig_clr,
   input  logic [LINES-1:0] wdata,
   input  logic [LINES-1:0] raw,
   output logic [LINES-1:0] mask_o,
   output logic [LINES-1:0] trig_o,
   output logic [LINES-1:0] pend_o
);
   logic [LINES-1:0] mask_q, trig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
         trig_q <= '0;
      end else if (srst) begin
         mask_q <= '1;
         trig_q <= '0;
      end else begin
         if (mask_set)      mask_q <= mask_q | wdata;
         else if (mask_clr) mask_q <= mask_q & ~wdata;
         if (trig_set)      trig_q <= trig_q | wdata;
         else if (trig_clr) trig_q <= trig_q & ~wdata;
      end
   end

   assign mask_o = mask_q;
   assign trig_o = trig_q;
   assign pend_o = (raw | trig_q) & ~mask_q;
endmodule

// File: rtl/irqv_pick.sv
module irqv_pick #(
   parameter int N    = 128,
   localparam int ID_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]    req,
   output logic            found,
   output logic [ID_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = ID_W'(i);
         end
      end
   end
endmodule

// File: rtl/irqv_srst.sv
module irqv_srst #(
   parameter int CYCLES = 4,
   localparam int CW = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (start)        cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
   import irqv_pkg::*;
#(
   parameter int NUM_BANKS   = 4,
   parameter int ADDR_W      = 8,
   parameter int SRST_CYCLES = 4,
   parameter int REV_MAJOR   = 2,
   parameter int REV_MINOR   = 1,
   parameter int THRESH_W    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_BANKS*WORD_W-1:0] irq_in,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic                        bus_wr_en,
   input  logic [WORD_W-1:0]           bus_wdata,
   input  logic                        bus_rd_en,
   output logic [WORD_W-1:0]           bus_rdata,
   output logic                        cpu_irq
);
   localparam int NUM_LINES = NUM_BANKS * WORD_W;
   localparam int ID_W      = $clog2(NUM_LINES);
   localparam logic [THRESH_W-1:0] THRESH_RST = '1;

   generate
      if (NUM_BANKS < 1 || NUM_BANKS > 4)
         $error("irqv_ctrl: NUM_BANKS must be 1..4");
      if (bank_addr(NUM_BANKS - 1, BK_TRIG_CLR) >= (1 << ADDR_W))
         $error("irqv_ctrl: ADDR_W too small for bank registers");
      if (SRST_CYCLES < 1)
         $error("irqv_ctrl: SRST_CYCLES must be at least 1");
      if (THRESH_W < 1 || THRESH_W > WORD_W)
         $error("irqv_ctrl: THRESH_W out of range");
      if (REV_MAJOR > 15 || REV_MINOR > 15 || REV_MAJOR < 0 || REV_MINOR < 0)
         $error("irqv_ctrl: revision fields are 4 bits");
   endgenerate

   logic                  busy, wr_ok, srst_start, eoi, srst_any;
   logic [NUM_LINES-1:0]  pend;
   logic [NUM_BANKS-1:0][WORD_W-1:0] mask_w, trig_w;
   logic                  found;
   logic [ID_W-1:0]       win;
   logic                  vec_valid_q;
   logic [ID_W-1:0]       vec_q;
   logic [THRESH_W-1:0]   thresh_q;
   logic [WORD_W-1:0]     rd_mux;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
      return a == ADDR_W'(ofs);
   endfunction

   assign wr_ok      = bus_wr_en && !busy;
   assign srst_start = wr_ok && hit(bus_addr, OFS_SYSCFG) && bus_wdata[CFG_SRST_BIT];
   assign eoi        = wr_ok && hit(bus_addr, OFS_CTRL) && bus_wdata[CTRL_EOI_BIT];
   assign srst_any   = srst_start || busy;

   irqv_srst #(.CYCLES(SRST_CYCLES)) u_srst (
      .clk   (clk),
      .rst_n (rst_n),
      .start (srst_start),
      .busy  (busy)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      irqv_bank #(.LINES(WORD_W)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .srst     (srst_any),
         .mask_clr (wr_ok && hit(bus_addr, bank_addr(b, BK_MASK_CLR))),
         .mask_set (wr_ok && hit(bus_addr, bank_addr(b, BK_MASK_SET))),
         .trig_set (wr_ok && hit(bus_addr, bank_addr(b, BK_TRIG_SET))),
         .trig_clr (wr_ok && hit(bus_addr, bank_addr(b, BK_TRIG_CLR))),
         .wdata    (bus_wdata),
         .raw      (irq_in[b*WORD_W +: WORD_W]),
         .mask_o   (mask_w[b]),
         .trig_o   (trig_w[b]),
         .pend_o   (pend[b*WORD_W +: WORD_W])
      );
   end

   irqv_pick #(.N(NUM_LINES)) u_pick (
      .req   (pend),
      .found (found),
      .idx   (win)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_valid_q <= 1'b0;
         vec_q       <= '0;
      end else if (srst_any) begin
         vec_valid_q <= 1'b0;
         vec_q       <= '0;
      end else if (eoi || !vec_valid_q) begin
         vec_valid_q <= found;
         vec_q       <= found ? win : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              thresh_q <= THRESH_RST;
      else if (srst_any)                       thresh_q <= THRESH_RST;
      else if (wr_ok && hit(bus_addr, OFS_THRESH)) thresh_q <= bus_wdata[THRESH_W-1:0];
   end

   always_comb begin
      rd_mux = '0;
      if (hit(bus_addr, OFS_REV)) begin
         rd_mux[7:4] = 4'(REV_MAJOR);
         rd_mux[3:0] = 4'(REV_MINOR);
      end else if (hit(bus_addr, OFS_SYSSTAT)) begin
         rd_mux[0] = !busy;
      end else if (hit(bus_addr, OFS_ACTIVE)) begin
         rd_mux[ID_W-1:0] = vec_q;
         rd_mux[SPUR_BIT] = !vec_valid_q || !pend[vec_q];
      end else if (hit(bus_addr, OFS_THRESH)) begin
         rd_mux[THRESH_W-1:0] = thresh_q;
      end
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (hit(bus_addr, bank_addr(b, BK_MASK_CLR)) || hit(bus_addr, bank_addr(b, BK_MASK_SET)))
            rd_mux = mask_w[b];
         if (hit(bus_addr, bank_addr(b, BK_TRIG_SET)) || hit(bus_addr, bank_addr(b, BK_TRIG_CLR)))
            rd_mux = trig_w[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bus_rdata <= '0;
      else if (bus_rd_en) bus_rdata <= rd_mux;
   end

   assign cpu_irq = vec_valid_q;
endmodule

// File: rtl/irqv_ctrl_chk.sv
module irqv_ctrl_chk #(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 8,
   localparam int NUM_LINES = NUM_BANKS * 32,
   localparam int ID_W      = $clog2(NUM_LINES)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic                 bus_wr_en,
   input logic                 wd_bit0,
   input logic                 wd_bit1,
   input logic                 bus_rd_en,
   input logic [31:0]          bus_rdata,
   input logic                 cpu_irq,
   input logic                 busy,
   input logic [NUM_LINES-1:0] pend,
   input logic [ID_W-1:0]      vec_q
);
   logic eoi_wr, cfg_wr, srst_wr;
   assign eoi_wr  = bus_wr_en && !busy && bus_addr == ADDR_W'('h48) && wd_bit0;
   assign cfg_wr  = bus_wr_en && (bus_addr == ADDR_W'('h10) || bus_addr == ADDR_W'('h48));
   assign srst_wr = bus_wr_en && bus_addr == ADDR_W'('h10) && wd_bit1;

   AST_EOI_EMPTY_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && pend == '0) |=> !cpu_irq); // R8
   AST_IDLE_PICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_irq && !busy && pend != '0 && !srst_wr) |=> cpu_irq); // R7
   AST_VECTOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_irq && !busy && !cfg_wr) |=> $stable(vec_q)); // R8
   AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cpu_irq); // R10
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_en && bus_addr == ADDR_W'('h04)) |=> bus_rdata == '0); // R2
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_en |=> $stable(bus_rdata)); // R2
endmodule

bind irqv_ctrl irqv_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr_en (bus_wr_en),
   .wd_bit0   (bus_wdata[0]),
   .wd_bit1   (bus_wdata[1]),
   .bus_rd_en (bus_rd_en),
   .bus_rdata (bus_rdata),
   .cpu_irq   (cpu_irq),
   .busy      (busy),
   .pend      (pend),
   .vec_q     (vec_q)
);

// File: tb/irqv_ctrl_bench.sv
`timescale 1ns/1ps
module irqv_ctrl_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [127:0] irq_in = '0;
   logic [7:0]   bus_addr = '0;
   logic         bus_wr_en = 1'b0;
   logic [31:0]  bus_wdata = '0;
   logic         bus_rd_en = 1'b0;
   logic [31:0]  bus_rdata;
   logic         cpu_irq;

   int errors = 0;
   int checks = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;

   always #2.5 clk = ~clk;

   irqv_ctrl u_irqv_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .bus_addr(bus_addr), .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
      .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
   );

   // Monitor: a read strobed at one edge is compared at the following negedge.
   always @(posedge clk) rd_seen <= bus_rd_en;
   always @(negedge clk) begin
      if (rd_seen) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (bus_rdata !== e) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", t, bus_rdata, e);
         end
      end
   end

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic expect_read(input logic [7:0] a, input logic [31:0] e, input string t);
      @(negedge clk);
      bus_addr = a; bus_rd_en = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      bus_rd_en = 1'b0;
   endtask

   task automatic expect_irq(input logic e, input string t);
      @(negedge clk);
      checks++;
      if (cpu_irq !== e) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", t, cpu_irq, e);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      idle(3);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(5ns * 20000);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      expect_irq(1'b0, "R1 irq after reset");
      expect_read(8'h14, 32'h1, "R1 status done");
      expect_read(8'h68, 32'hFF, "R1 threshold");
      expect_read(8'h00, 32'h21, "R11 revision");
      expect_read(8'h88, 32'hFFFF_FFFF, "R1 bank0 mask");
      expect_read(8'hEC, 32'hFFFF_FFFF, "R3 bank3 mask");
      expect_read(8'h90, 32'h0, "R1 bank0 trigger");
      expect_read(8'h40, 32'h80, "R9 idle active");
      expect_read(8'h04, 32'h0, "R2 unmapped 0x04");
      expect_read(8'hF8, 32'h0, "R2 unmapped 0xF8");
      // R5 masked input
      irq_in[5] = 1'b1;
      idle(3);
      expect_irq(1'b0, "R5 masked line");
      // unmask line 5
      bus_write(8'h88, 32'h20);
      expect_read(8'h8C, 32'hFFFF_FFDF, "R4 w1c mask");
      expect_irq(1'b1, "R7 irq raised");
      expect_read(8'h40, 32'h05, "R9 active 5");
      bus_write(8'h40, 32'h0);
      expect_read(8'h40, 32'h05, "R9 write ignored");
      // line 40 and line 3 (software)
      irq_in[40] = 1'b1;
      bus_write(8'hA8, 32'h100);
      expect_read(8'hAC, 32'hFFFF_FEFF, "R3 bank1 mask");
      bus_write(8'h90, 32'h8);
      bus_write(8'h88, 32'h8);
      expect_read(8'h94, 32'h8, "R3 trigger read");
      expect_read(8'h40, 32'h05, "R8 held without eoi");
      bus_write(8'h48, 32'h1);
      expect_read(8'h40, 32'h03, "R6 lowest wins");
      bus_write(8'h90, 32'h1);
      expect_read(8'h90, 32'h9, "R4 w1s keeps bits");
      bus_write(8'h94, 32'h8);
      expect_read(8'h94, 32'h1, "R4 w1c trigger");
      expect_read(8'h40, 32'h83, "R9 spurious");
      expect_irq(1'b1, "R8 still latched");
      bus_write(8'h48, 32'h1);
      expect_read(8'h40, 32'h05, "R8 eoi picks 5");
      irq_in[5] = 1'b0;
      bus_write(8'h48, 32'h1);
      expect_read(8'h40, 32'h28, "R3 line 40");
      bus_write(8'hAC, 32'h100);
      expect_read(8'h40, 32'hA8, "R9 masked after latch");
      bus_write(8'h48, 32'h1);
      expect_irq(1'b0, "R8 eoi empty idles");
      expect_read(8'h40, 32'h80, "R9 idle after eoi");
      // collision: eoi and new lower line on the same edge
      bus_write(8'h88, 32'h204);
      irq_in[9] = 1'b1;
      idle(2);
      expect_read(8'h40, 32'h09, "R7 line 9");
      @(negedge clk);
      irq_in[2] = 1'b1;
      bus_addr = 8'h48; bus_wdata = 32'h1; bus_wr_en = 1'b1;
      @(negedge clk);
      bus_wr_en = 1'b0;
      expect_read(8'h40, 32'h02, "R8 eoi samples same-edge input");
      // line 127 via software trigger
      irq_in[2] = 1'b0;
      irq_in[9] = 1'b0;
      bus_write(8'hE8, 32'h8000_0000);
      bus_write(8'hF0, 32'h8000_0000);
      bus_write(8'h48, 32'h1);
      expect_read(8'h40, 32'h7F, "R5 line 127 trigger");
      bus_write(8'h68, 32'h20);
      expect_read(8'h68, 32'h20, "R11 threshold rw");
      expect_irq(1'b1, "R11 threshold no effect");
      // soft reset
      bus_write(8'h10, 32'h2);
      expect_read(8'h14, 32'h0, "R10 busy");
      bus_write(8'h88, 32'hFFFF_FFFF);
      idle(5);
      expect_read(8'h14, 32'h1, "R10 done");
      expect_irq(1'b0, "R10 irq cleared");
      expect_read(8'h88, 32'hFFFF_FFFF, "R10 masks restored");
      expect_read(8'hF0, 32'h0, "R10 triggers cleared");
      expect_read(8'h68, 32'hFF, "R10 threshold restored");
      expect_read(8'h40, 32'h80, "R10 vector cleared");
      idle(2);
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R2 actual=%0d expected=0 unanswered reads", exp_q.size());
      end
      finish_run();
   end
endmodule